// File: doc/BRIEF.md
# Barrier Ordering Safety Monitor

This block is a passive watcher placed next to a barrier unit that serves two threads, called A and B. Each cycle it looks at both threads' current opcode and program counter and decides whether each thread is sitting on a barrier. A select input chooses how a barrier is recognised. In one mode the opcode is compared with a barrier opcode. In the other mode the PC is compared with a fixed barrier address, which is the barrier's instruction index times the instruction size in bytes.

Thread A has passed the barrier when it was on the barrier in one cycle and is off it in the next. Thread B has arrived once it has been seen on the barrier in any cycle. Both events are kept as sticky flags. A registered ordering property holds while A has not passed or B has arrived. When the property drops, a violation output latches high until reset, and a single-cycle marker flags the first failing cycle. The block does not model the barrier, thread scheduling or instruction execution. It is meant to drive simulation assertions or to act as a bounded formal target.

Top module: `barmon_top`

## Requirements
- R1: After a synchronous active-high reset, `order_ok` is 1, `order_violated` is 0 and `first_violation` is 0.
- R2: With `match_by_pc` = 0, a thread is on the barrier exactly when its opcode equals parameter `BAR_OPCODE` (default 6'h1A). Its PC has no effect on the outputs in this mode.
- R3: With `match_by_pc` = 1, a thread is on the barrier exactly when its PC equals `BAR_INDEX*INSN_BYTES` (default 12*4 = 48). Its opcode has no effect on the outputs in this mode.
- R4: Suppose A is sampled on the barrier at clock edge e and off it at edge e+1, and B has not been sampled on the barrier at or before edge e+1. Then `order_ok` stays 1 after edge e+1 and is 0 after edge e+2.
- R5: If B is sampled on the barrier at any edge up to and including the edge at which A is first sampled off the barrier, `order_ok` stays 1.
- R6: A that stays on the barrier for any number of cycles, or that never reaches it, never clears `order_ok`.
- R7: `order_violated` is 1 in every cycle in which `order_ok` is 0. Once set, it stays 1 until reset, even if `order_ok` later returns to 1.
- R8: `first_violation` is high for exactly one cycle, the first cycle after reset in which `order_ok` is 0.
- R9: Both the passed and arrived flags are sticky. If B arrives after A has passed, `order_ok` is 1 again after the second edge from the edge at which B was sampled on the barrier.
- R10: Reset clears the one-cycle history of A. If A was on the barrier before reset and is off it afterwards, that is not counted as passing the barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| match_by_pc | input | 1 | 0: recognise barrier by opcode; 1: by PC address |
| a_opcode | input | OPC_W | Thread A current opcode |
| a_pc | input | PC_W | Thread A current program counter |
| b_opcode | input | OPC_W | Thread B current opcode |
| b_pc | input | PC_W | Thread B current program counter |
| order_ok | output | 1 | Registered ordering property |
| order_violated | output | 1 | Sticky violation flag |
| first_violation | output | 1 | One-cycle marker of the first failing cycle |

## Verification
Embedded assertions check several relations on every cycle. Both event flags must stay set once set. The property register must follow the flags one edge later. The violation flag must never drop, and the first-failure marker must never last two cycles. Only the bench scenarios can show the exact edge at which a crossing becomes visible, the same-edge race between A leaving and B arriving, and which field each mode ignores. They also show that reset breaks A's history, and that the property recovers while the violation stays latched.

// File: rtl/barmon_pkg.sv
package barmon_pkg;

  typedef enum logic {
    MATCH_OPCODE = 1'b0,
    MATCH_PC     = 1'b1
  } match_mode_e;

  // Falling edge of the per-cycle on-barrier condition
  function automatic logic left_barrier(input logic now_on, input logic was_on);
    return was_on & ~now_on;
  endfunction

  // Ordering property: fine until A has passed, or once B has arrived
  function automatic logic order_holds(input logic passed, input logic arrived);
    return ~passed | arrived;
  endfunction

endpackage

// File: rtl/barmon_detect.sv
module barmon_detect #(
  parameter int                 OPC_W      = 6,
  parameter int                 PC_W       = 16,
  parameter logic [OPC_W-1:0]   BAR_OPCODE = 6'h1A,
  parameter logic [PC_W-1:0]    BAR_ADDR   = 16'd48
) (
  input  barmon_pkg::match_mode_e mode,
  input  logic [OPC_W-1:0]        opcode,
  input  logic [PC_W-1:0]         pc,
  output logic                    on_barrier
);
  import barmon_pkg::*;

  logic opc_hit;
  logic pc_hit;

  assign opc_hit = (opcode == BAR_OPCODE);
  assign pc_hit  = (pc == BAR_ADDR);

  always_comb begin
    unique case (mode)
      MATCH_PC: on_barrier = pc_hit;
      default:  on_barrier = opc_hit;
    endcase
  end

endmodule

// File: rtl/barmon_track.sv
module barmon_track (
  input  logic clk,
  input  logic rst,
  input  logic a_on,
  input  logic b_on,
  output logic a_left,
  output logic passed_q,
  output logic arrived_q,
  output logic prop_q
);
  import barmon_pkg::*;

  logic a_prev_q;

  assign a_left = left_barrier(a_on, a_prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_prev_q  <= 1'b0;
      passed_q  <= 1'b0;
      arrived_q <= 1'b0;
      prop_q    <= 1'b1;
    end else begin
      a_prev_q  <= a_on;
      passed_q  <= passed_q | a_left;
      arrived_q <= arrived_q | b_on;
      prop_q    <= order_holds(passed_q, arrived_q);
    end
  end

  // R9
  passed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    passed_q |=> passed_q);

  // R9
  arrived_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    arrived_q |=> arrived_q);

  // R4
  prop_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (passed_q && !arrived_q) |=> !prop_q);

  // R5
  prop_arrived_chk: assert property (@(posedge clk) disable iff (rst)
    arrived_q |=> prop_q);

  // R6
  prop_not_passed_chk: assert property (@(posedge clk) disable iff (rst)
    !passed_q |=> prop_q);

endmodule

// File: rtl/barmon_latch.sv
module barmon_latch (
  input  logic clk,
  input  logic rst,
  input  logic prop_q,
  output logic violated,
  output logic first_fail
);
  logic seen_q;

  assign first_fail = ~prop_q & ~seen_q;
  assign violated   = ~prop_q | seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= seen_q | ~prop_q;
  end

  // R7
  violation_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    violated |=> violated);

  // R8
  first_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    first_fail |=> !first_fail);

  // R8
  first_needs_fail_chk: assert property (@(posedge clk) disable iff (rst)
    first_fail |-> !prop_q);

endmodule

// File: rtl/barmon_top.sv
module barmon_top #(
  parameter int               OPC_W      = 6,
  parameter int               PC_W       = 16,
  parameter logic [OPC_W-1:0] BAR_OPCODE = 6'h1A,
  parameter int               BAR_INDEX  = 12,
  parameter int               INSN_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             match_by_pc,
  input  logic [OPC_W-1:0] a_opcode,
  input  logic [PC_W-1:0]  a_pc,
  input  logic [OPC_W-1:0] b_opcode,
  input  logic [PC_W-1:0]  b_pc,
  output logic             order_ok,
  output logic             order_violated,
  output logic             first_violation
);
  import barmon_pkg::*;

  localparam int              NTHREADS = 2;
  localparam logic [PC_W-1:0] BAR_ADDR = PC_W'(BAR_INDEX * INSN_BYTES);

  match_mode_e      mode;
  logic [OPC_W-1:0] opc_v [NTHREADS];
  logic [PC_W-1:0]  pc_v  [NTHREADS];
  logic             on_v  [NTHREADS];

  logic a_left;
  logic passed_q;
  logic arrived_q;
  logic prop_q;

  assign mode     = match_mode_e'(match_by_pc);
  assign opc_v[0] = a_opcode;
  assign opc_v[1] = b_opcode;
  assign pc_v[0]  = a_pc;
  assign pc_v[1]  = b_pc;

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thread
    barmon_detect #(
      .OPC_W(OPC_W), .PC_W(PC_W),
      .BAR_OPCODE(BAR_OPCODE), .BAR_ADDR(BAR_ADDR)
    ) u_det (
      .mode(mode), .opcode(opc_v[t]), .pc(pc_v[t]), .on_barrier(on_v[t])
    );
  end

  barmon_track u_track (
    .clk(clk), .rst(rst), .a_on(on_v[0]), .b_on(on_v[1]),
    .a_left(a_left), .passed_q(passed_q), .arrived_q(arrived_q), .prop_q(prop_q)
  );

  barmon_latch u_latch (
    .clk(clk), .rst(rst), .prop_q(prop_q),
    .violated(order_violated), .first_fail(first_violation)
  );

  assign order_ok = prop_q;

  // R4
  leave_sets_passed_chk: assert property (@(posedge clk) disable iff (rst)
    a_left |=> passed_q);

endmodule

// File: tb/sim_barmon_top.sv
module sim_barmon_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0]  BOP = 6'h1A;
  localparam logic [5:0]  NOP = 6'h00;
  localparam logic [15:0] BPC = 16'd48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic match_by_pc = 1'b0;
  logic [5:0]  a_opcode = NOP, b_opcode = NOP;
  logic [15:0] a_pc = 16'd0, b_pc = 16'd0;
  logic order_ok, order_violated, first_violation;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  barmon_top u0 (
    .clk(clk), .rst(rst), .match_by_pc(match_by_pc),
    .a_opcode(a_opcode), .a_pc(a_pc), .b_opcode(b_opcode), .b_pc(b_pc),
    .order_ok(order_ok), .order_violated(order_violated),
    .first_violation(first_violation)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [5:0] ao, input logic [15:0] ap,
                       input logic [5:0] bo, input logic [15:0] bp);
    a_opcode = ao; a_pc = ap; b_opcode = bo; b_pc = bp;
  endtask

  task automatic check3(input string req, input logic ok, input logic vio, input logic ff);
    n_checks++;
    if (order_ok !== ok || order_violated !== vio || first_violation !== ff) begin
      n_fail++;
      $display("FAIL %s: ok/vio/first actual %b%b%b expected %b%b%b",
               req, order_ok, order_violated, first_violation, ok, vio, ff);
    end
  endtask

  task automatic do_reset();
    drive(NOP, 16'd0, NOP, 16'd0);
    rst = 1'b1; tick(); rst = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    do_reset();
    check3("R1", 1'b1, 1'b0, 1'b0);
  endtask

  // R4 R7 R8 R9: A passes with B absent, then B arrives late
  task automatic t_cross_alone();
    match_by_pc = 1'b0; do_reset();
    drive(BOP, 16'd4, NOP, 16'd0); tick();
    drive(NOP, 16'd8, NOP, 16'd0); tick();
    check3("R4", 1'b1, 1'b0, 1'b0);
    tick();
    check3("R4", 1'b0, 1'b1, 1'b1);
    tick();
    check3("R8", 1'b0, 1'b1, 1'b0);
    drive(NOP, 16'd8, BOP, 16'd0); tick();
    check3("R7", 1'b0, 1'b1, 1'b0);
    drive(NOP, 16'd8, NOP, 16'd4); tick();
    check3("R9", 1'b1, 1'b1, 1'b0);
    tick();
    check3("R7", 1'b1, 1'b1, 1'b0);
  endtask

  // R5: B arrives first
  task automatic t_b_first();
    match_by_pc = 1'b0; do_reset();
    drive(NOP, 16'd0, BOP, 16'd0); tick();
    drive(BOP, 16'd0, NOP, 16'd4); tick();
    drive(NOP, 16'd4, NOP, 16'd4);
    for (int i = 0; i < 3; i++) begin
      tick();
      check3("R5", 1'b1, 1'b0, 1'b0);
    end
  endtask

  // R5: B arrives at the same edge A leaves
  task automatic t_same_edge();
    match_by_pc = 1'b0; do_reset();
    drive(BOP, 16'd0, NOP, 16'd0); tick();
    drive(NOP, 16'd4, BOP, 16'd0); tick();
    drive(NOP, 16'd4, NOP, 16'd4); tick(); tick();
    check3("R5", 1'b1, 1'b0, 1'b0);
  endtask

  // R6: A holds on the barrier, or never reaches it
  task automatic t_hold();
    match_by_pc = 1'b0; do_reset();
    drive(BOP, 16'd0, NOP, 16'd0);
    for (int i = 0; i < 6; i++) tick();
    check3("R6", 1'b1, 1'b0, 1'b0);
    do_reset();
    drive(6'h05, 16'd20, NOP, 16'd0);
    for (int i = 0; i < 4; i++) tick();
    check3("R6", 1'b1, 1'b0, 1'b0);
  endtask

  // R2: PC ignored in opcode mode
  task automatic t_opc_mode();
    match_by_pc = 1'b0; do_reset();
    drive(NOP, BPC, NOP, 16'd0); tick();
    drive(NOP, 16'd52, NOP, 16'd0); tick(); tick();
    check3("R2", 1'b1, 1'b0, 1'b0);
  endtask

  // R3: opcode ignored in PC mode, PC match works for A and B
  task automatic t_pc_mode();
    match_by_pc = 1'b1; do_reset();
    drive(BOP, 16'd0, NOP, 16'd0); tick();
    drive(NOP, 16'd4, NOP, 16'd0); tick(); tick();
    check3("R3", 1'b1, 1'b0, 1'b0);
    drive(NOP, BPC, BOP, 16'd0); tick();
    drive(NOP, 16'd52, BOP, 16'd0); tick(); tick();
    check3("R3", 1'b0, 1'b1, 1'b1);
    do_reset();
    drive(NOP, 16'd0, NOP, BPC); tick();
    drive(NOP, BPC, NOP, 16'd52); tick();
    drive(NOP, 16'd52, NOP, 16'd52); tick(); tick();
    check3("R3", 1'b1, 1'b0, 1'b0);
    match_by_pc = 1'b0;
  endtask

  // R10: history cleared by reset
  task automatic t_reset_history();
    match_by_pc = 1'b0; do_reset();
    drive(BOP, 16'd0, NOP, 16'd0); tick();
    rst = 1'b1; tick();
    check3("R1", 1'b1, 1'b0, 1'b0);
    rst = 1'b0;
    drive(NOP, 16'd4, NOP, 16'd0); tick(); tick(); tick();
    check3("R10", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #2;
    t_reset();
    t_cross_alone();
    t_b_first();
    t_same_edge();
    t_hold();
    t_opc_mode();
    t_pc_mode();
    t_reset_history();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule